// File: doc/BRIEF.md
# Serial Register Port with Read Snapshot

This block is the two-wire serial slave side of a clock-calendar: it lets a bus master write and read a small file of byte registers over open-drain SCL/SDA lines. The slave samples both lines into the system clock domain and finds START and STOP conditions and clock edges there. It drives SDA only by pulling it low, through an output enable. It answers one fixed 7-bit address. The first byte of a write transfer sets an internal register pointer. Each later byte is written at that pointer, and the pointer then steps forward and wraps at the top of the register space.

Reads do not come straight from the live counters. They come from a snapshot copy, so a multi-byte read of time fields stays consistent even if the counters tick during the transfer. The snapshot is refreshed from the live registers at every START, at every STOP, and whenever the pointer wraps back to zero. A master can read from wherever the pointer was left, or it can write the pointer and follow with a repeated START and a read. Each register write goes out as a one-cycle strobe with address and data. A write to register 0 also pulses a prescaler-reset output.

Top module: `rtc_i2c_port`

## Requirements
- R1: After reset the block does not pull SDA low and issues no register write strobe.
- R2: An address byte of 0xD0 (7-bit address 0x68, direction bit 0 = write) or 0xD1 (direction bit 1 = read) is acknowledged by holding SDA low through the high phase of the ninth clock.
- R3: In a write transfer, the first byte after the address loads the pointer (its low bits). Each following byte produces one write strobe carrying the current pointer and that byte, issued at its acknowledge clock, and the pointer then advances by one.
- R4: The pointer wraps from the last register (7) to 0, for both writes and reads.
- R5: A write to register 0 pulses the prescaler-reset output together with its write strobe. Writes to other registers do not pulse it.
- R6: A read transfer that does not first write the pointer starts at the pointer value left by the previous transfer.
- R7: A write of the pointer, then a repeated START with a read address, returns the registers from that pointer upward. Bytes go out MSB first.
- R8: Read data comes from a snapshot of the live registers. The snapshot is taken at each START or STOP and again when the pointer wraps to 0, so changes to the live registers between those moments are not seen.
- R9: The pointer also advances after a read byte that the master answers with NACK. After the NACK the slave releases SDA.
- R10: An address byte that does not match is not acknowledged. Bytes that follow it in the same transfer (even 0xD0) are not acknowledged and cause no write.
- R11: After a non-matching address, the next START with a matching address is acknowledged and served normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both bus lines are sampled on it |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the serial clock line |
| sdaIn | input | 1 | Sampled level of the serial data line |
| sdaOe | output | 1 | 1 pulls SDA low; 0 releases it |
| liveRegs | input | NUM_REGS*8 | Live register contents, register i at bits [8i+7:8i] |
| wrEn | output | 1 | One-cycle register write strobe |
| wrAddr | output | $clog2(NUM_REGS) | Register index of the write |
| wrData | output | 8 | Byte to be written |
| presetRst | output | 1 | One-cycle pulse when register 0 is written |

## Verification
The bench goes after the pointer in its awkward states. It writes across the top of the register space, reads past register 7, and reads after a NACK. A design that failed to wrap, or that advanced the pointer only on ACK, would return the wrong register on the next current-pointer read. The snapshot is tested by changing live registers after a repeated START: register 7 must still read its old value, while register 0, reached by wrapping, must show the new one. A design that read live data, or that skipped the wrap refresh, gets one of the two wrong. A mismatched address followed by 0xD0 in mid-transfer checks that the slave neither acknowledges nor writes until a real START.

// File: rtl/rtcI2cPkg.sv
package rtcI2cPkg;

  // Per-cycle commands from the bus controller to the datapath
  typedef struct packed {
    logic snapLoad;  // refresh snapshot from live registers
    logic rxShift;   // shift rxBit into the receive register
    logic rxBit;     // sampled SDA level
    logic ptrLoad;   // load pointer from received byte
    logic regWrite;  // write received byte at pointer, then advance
    logic ptrInc;    // advance pointer after a transmitted byte
    logic txLoad;    // load transmit register from snapshot[pointer]
    logic txShift;   // present next transmit bit
  } dpStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_RECV,   // receiving 8 bits
    ST_AWAIT,  // byte received, waiting for SCL low to acknowledge
    ST_ACK,    // holding SDA low for the ninth clock
    ST_SEND,   // transmitting 8 bits
    ST_MACK,   // waiting for master acknowledge
    ST_MNEXT,  // master acknowledged, next byte on SCL low
    ST_SKIP    // ignoring bus until START or STOP
  } busState_t;

endpackage

// File: rtl/rtc_i2c_ctrl.sv
module rtc_i2c_ctrl
  import rtcI2cPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h68,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [6:0] rxLow,
  input  logic       txBit,
  output dpStrobes_t stb,
  output logic       sdaOe
);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startCond, stopCond;
  busState_t state;
  logic [2:0] bitCnt;
  logic isAddr, rwBit, ptrLoaded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
    end
  end

  assign sclS      = sclSync[SYNC_STAGES-1];
  assign sdaS      = sdaSync[SYNC_STAGES-1];
  assign sclRise   = sclS & ~sclD;
  assign sclFall   = ~sclS & sclD;
  assign startCond = sclS & sclD & sdaD & ~sdaS;
  assign stopCond  = sclS & sclD & ~sdaD & sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD      <= 1'b1;
      sdaD      <= 1'b1;
      state     <= ST_IDLE;
      bitCnt    <= '0;
      isAddr    <= 1'b0;
      rwBit     <= 1'b0;
      ptrLoaded <= 1'b0;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
      if (startCond) begin
        state     <= ST_RECV;
        bitCnt    <= '0;
        isAddr    <= 1'b1;
        ptrLoaded <= 1'b0;
      end else if (stopCond) begin
        state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_RECV: if (sclRise) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) begin
              if (isAddr) rwBit <= sdaS;
              state <= (isAddr && rxLow != SLAVE_ADDR) ? ST_SKIP : ST_AWAIT;
            end
          end
          ST_AWAIT: if (sclFall) state <= ST_ACK;
          ST_ACK: begin
            if (sclRise && !isAddr) ptrLoaded <= 1'b1;
            if (sclFall) begin
              isAddr <= 1'b0;
              bitCnt <= '0;
              state  <= (isAddr && rwBit) ? ST_SEND : ST_RECV;
            end
          end
          ST_SEND: if (sclFall) begin
            bitCnt <= bitCnt + 3'd1;
            if (bitCnt == 3'd7) state <= ST_MACK;
          end
          ST_MACK: if (sclRise) state <= sdaS ? ST_SKIP : ST_MNEXT;
          ST_MNEXT: if (sclFall) begin
            bitCnt <= '0;
            state  <= ST_SEND;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    stb          = '0;
    stb.snapLoad = startCond | stopCond;
    stb.rxBit    = sdaS;
    stb.rxShift  = (state == ST_RECV) && sclRise;
    stb.ptrLoad  = (state == ST_ACK) && sclRise && !isAddr && !ptrLoaded;
    stb.regWrite = (state == ST_ACK) && sclRise && !isAddr && ptrLoaded;
    stb.txLoad   = sclFall && (((state == ST_ACK) && isAddr && rwBit) ||
                               (state == ST_MNEXT));
    stb.txShift  = (state == ST_SEND) && sclFall && (bitCnt != 3'd7);
    stb.ptrInc   = (state == ST_MACK) && sclRise;
  end

  assign sdaOe = (state == ST_ACK) || ((state == ST_SEND) && !txBit);

  // R11
  start_recv_chk: assert property (@(posedge clk) disable iff (!rstN)
    startCond |=> (state == ST_RECV) && isAddr);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopCond && !startCond) |=> (state == ST_IDLE));

  // R10
  addr_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RECV) && isAddr && sclRise && (bitCnt == 3'd7) &&
     (rxLow != SLAVE_ADDR) && !startCond && !stopCond) |=> (state == ST_SKIP));

  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_MACK) && sclRise && sdaS && !startCond && !stopCond) |=> !sdaOe);

endmodule

// File: rtl/rtc_i2c_dp.sv
module rtc_i2c_dp
  import rtcI2cPkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobes_t                  stb,
  input  logic [NUM_REGS*8-1:0]       liveRegs,
  output logic [7:0]                  rxByte,
  output logic                        txBit,
  output logic                        wrEn,
  output logic [$clog2(NUM_REGS)-1:0] wrAddr,
  output logic [7:0]                  wrData,
  output logic                        presetRst
);

  localparam int PTR_W = $clog2(NUM_REGS);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(NUM_REGS - 1);

  logic [PTR_W-1:0] ptr;
  logic [7:0] txReg;
  logic [7:0] snap [NUM_REGS];
  logic [NUM_REGS*8-1:0] snapFlat;
  logic advance, reload;

  assign advance = stb.ptrInc | stb.regWrite;
  assign reload  = stb.snapLoad | (advance && ptr == PTR_MAX);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_snap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       snap[g] <= '0;
      else if (reload) snap[g] <= liveRegs[g*8 +: 8];
    end
    assign snapFlat[g*8 +: 8] = snap[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      rxByte    <= '0;
      txReg     <= 8'hFF;
      wrEn      <= 1'b0;
      wrAddr    <= '0;
      wrData    <= '0;
      presetRst <= 1'b0;
    end else begin
      if (stb.rxShift) rxByte <= {rxByte[6:0], stb.rxBit};
      if (stb.ptrLoad)  ptr <= rxByte[PTR_W-1:0];
      else if (advance) ptr <= (ptr == PTR_MAX) ? '0 : ptr + 1'b1;
      if (stb.txLoad)       txReg <= snap[ptr];
      else if (stb.txShift) txReg <= {txReg[6:0], 1'b1};
      wrEn      <= stb.regWrite;
      presetRst <= stb.regWrite && (ptr == '0);
      if (stb.regWrite) begin
        wrAddr <= ptr;
        wrData <= rxByte;
      end
    end
  end

  assign txBit = txReg[7];

  // R3
  wr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.regWrite |=> wrEn && (wrAddr == $past(ptr)) && (wrData == $past(rxByte)));

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !stb.ptrLoad && ptr == PTR_MAX) |=> (ptr == '0));

  // R5
  preset_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    presetRst |-> wrEn && (wrAddr == '0));

  // R8
  snap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> (snapFlat == $past(liveRegs)));

endmodule

// File: rtl/rtc_i2c_port.sv
module rtc_i2c_port
  import rtcI2cPkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h68,
  parameter int         NUM_REGS   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        sclIn,
  input  logic                        sdaIn,
  output logic                        sdaOe,
  input  logic [NUM_REGS*8-1:0]       liveRegs,
  output logic                        wrEn,
  output logic [$clog2(NUM_REGS)-1:0] wrAddr,
  output logic [7:0]                  wrData,
  output logic                        presetRst
);

  dpStrobes_t stb;
  logic [7:0] rxByte;
  logic txBit;

  rtc_i2c_ctrl #(.SLAVE_ADDR(SLAVE_ADDR), .SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rxLow(rxByte[6:0]), .txBit(txBit), .stb(stb), .sdaOe(sdaOe)
  );

  rtc_i2c_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .liveRegs(liveRegs),
    .rxByte(rxByte), .txBit(txBit), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .presetRst(presetRst)
  );

endmodule

// File: tb/rtc_i2c_port_bench.sv
`timescale 1ns/1ps
module rtc_i2c_port_bench;

  localparam int T = 100;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, wrEn, presetRst;
  logic [2:0] wrAddr;
  logic [7:0] wrData;
  logic [7:0] live [8];
  logic [63:0] liveFlat;
  wire sdaBus = sdaM & ~sdaOe;

  int checks = 0, errors = 0, wrCount = 0, presetCount = 0;
  bit done = 1'b0;

  always_comb for (int i = 0; i < 8; i++) liveFlat[i*8 +: 8] = live[i];

  rtc_i2c_port u_rtc_i2c_port (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .liveRegs(liveFlat), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .presetRst(presetRst)
  );

  always @(posedge clk) begin
    if (wrEn) begin
      live[wrAddr] <= wrData;
      wrCount <= wrCount + 1;
    end
    if (presetRst) presetCount <= presetCount + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; #T; sclM = 1'b1; #T; sdaM = 1'b0; #T; sclM = 1'b0; #20;
  endtask

  task automatic busStop();
    sdaM = 1'b0; #T; sclM = 1'b1; #T; sdaM = 1'b1; #T;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; #T; sclM = 1'b1; #T; sclM = 1'b0; #20;
    end
    sdaM = 1'b1; #T; sclM = 1'b1; #(T/2); ack = sdaBus; #(T/2); sclM = 1'b0; #20;
  endtask

  task automatic readByte(input bit masterAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #T; sclM = 1'b1; #(T/2); b[i] = sdaBus; #(T/2); sclM = 1'b0; #20;
    end
    sdaM = !masterAck; #T; sclM = 1'b1; #T; sclM = 1'b0; #20; sdaM = 1'b1;
  endtask

  task automatic testReset();
    #3;
    check("R1 sdaOe in reset", sdaOe, 0);
    check("R1 wrEn in reset", wrEn, 0);
  endtask

  task automatic testWrite();
    logic ack;
    int w0;
    w0 = wrCount;
    busStart();
    sendByte(8'hD0, ack); check("R2 write address ack", ack, 0);
    sendByte(8'h02, ack); check("R3 pointer byte ack", ack, 0);
    sendByte(8'h11, ack); check("R3 data ack", ack, 0);
    sendByte(8'h22, ack);
    busStop();
    check("R3 write count", wrCount - w0, 2);
    check("R3 reg2", live[2], 8'h11);
    check("R3 reg3", live[3], 8'h22);
    check("R5 no preset for reg2/3", presetCount, 0);
  endtask

  task automatic testCurrentRead();
    logic ack;
    logic [7:0] b;
    busStart();
    sendByte(8'hD1, ack); check("R2 read address ack", ack, 0);
    readByte(1'b0, b); check("R6 current pointer read", b, 8'h44);
    #40; check("R9 SDA released after NACK", sdaOe, 0);
    busStop();
    busStart();
    sendByte(8'hD1, ack);
    readByte(1'b0, b); check("R9 pointer advanced after NACK", b, 8'h45);
    busStop();
  endtask

  task automatic testWrapWrite();
    logic ack;
    int p0;
    p0 = presetCount;
    busStart();
    sendByte(8'hD0, ack); sendByte(8'h06, ack);
    sendByte(8'hA6, ack); sendByte(8'hA7, ack); sendByte(8'hA0, ack);
    busStop();
    check("R4 write reg6", live[6], 8'hA6);
    check("R4 write reg7", live[7], 8'hA7);
    check("R4 write wraps to reg0", live[0], 8'hA0);
    check("R5 preset on reg0 write", presetCount - p0, 1);
  endtask

  task automatic testRepStartRead();
    logic ack;
    logic [7:0] b;
    busStart();
    sendByte(8'hD0, ack); sendByte(8'h05, ack);
    busStart();
    sendByte(8'hD1, ack); check("R7 ack after repeated START", ack, 0);
    readByte(1'b1, b); check("R7 read reg5", b, 8'h45);
    readByte(1'b1, b); check("R7 read reg6", b, 8'hA6);
    readByte(1'b1, b); check("R7 read reg7", b, 8'hA7);
    readByte(1'b0, b); check("R4 read wraps to reg0", b, 8'hA0);
    busStop();
  endtask

  task automatic testSnapshot();
    logic ack;
    logic [7:0] b;
    busStart();
    sendByte(8'hD0, ack); sendByte(8'h06, ack);
    busStart();
    sendByte(8'hD1, ack);
    live[7] = 8'h77;
    live[0] = 8'hE0;
    readByte(1'b1, b); check("R8 reg6 from snapshot", b, 8'hA6);
    readByte(1'b1, b); check("R8 reg7 keeps snapshot value", b, 8'hA7);
    readByte(1'b0, b); check("R8 reg0 refreshed at wrap", b, 8'hE0);
    busStop();
  endtask

  task automatic testMismatch();
    logic ack;
    logic [7:0] b;
    int w0;
    w0 = wrCount;
    busStart();
    sendByte(8'hA0, ack); check("R10 mismatch NACK", ack, 1);
    sendByte(8'hD0, ack); check("R10 mid-transfer D0 ignored", ack, 1);
    sendByte(8'h00, ack); check("R10 later byte ignored", ack, 1);
    check("R10 no write", wrCount - w0, 0);
    busStart();
    sendByte(8'hD1, ack); check("R11 ack after new START", ack, 0);
    readByte(1'b0, b); check("R11 read at pointer", b, 8'h41);
    busStop();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) live[i] = 8'h40 + 8'(i);
    testReset();
    #20 rstN = 1'b1;
    #50;
    testWrite();
    testCurrentRead();
    testWrapWrite();
    testRepStartRead();
    testSnapshot();
    testMismatch();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule